// File: doc/BRIEF.md
# Order-Independent NaN Result Stage

This block sits directly behind a single-precision (binary32) arithmetic core. It receives the core's two source operands, the numeric result the core produced, and a flag the core raises when it has just created an invalid result from non-NaN inputs (0/0, square root of a negative value and so on). From these it selects the final result so that NaN propagation cannot depend on operand order: `a op b` and `b op a` always leave the block as the same 32-bit pattern.

When only one operand is a NaN, that NaN passes through with its sign and payload. When both are NaNs, a two-bit policy input decides how they combine: the NaN with the larger payload wins (the default), the payloads are merged by bitwise OR, or the NaN with the smaller payload wins. Every NaN that leaves the block is quiet. A separate invalid output reports signaling inputs and core-generated invalid results. By default the result and flag are registered, so they appear one clock after the inputs.

Top module: `nanprop_unit`

## Requirements
- R1: When neither operand is a NaN and the core invalid flag is low, the result equals the core result bit for bit. Infinity (exponent bits [30:23] all ones, bits [22:0] zero) is not a NaN.
- R2: An operand is a NaN when bits [30:23] are all ones and bits [22:0] are nonzero. The payload is bits [21:0] and bit 22 is the quiet bit. When exactly one operand is a NaN, the result has that operand's sign, exponent all ones, bit 22 set, and its payload.
- R3: A signaling NaN input (bit 22 clear) is quieted on output and keeps its payload and sign.
- R4: With policy 2'b00 and both operands NaN, the result carries the sign and payload of the operand whose payload is numerically larger.
- R5: With policy 2'b01 and both operands NaN, the result payload is the bitwise OR of both payloads and the sign is the OR of both signs.
- R6: With policy 2'b10 and both operands NaN, the result carries the sign and payload of the operand whose payload is numerically smaller.
- R7: Under policy 2'b00 or 2'b10 with equal payloads, the result sign is the OR of both input signs.
- R8: Policy 2'b11 behaves exactly as policy 2'b00.
- R9: When neither operand is a NaN and the core invalid flag is high, the result is the quiet NaN 0x7FC00000 (sign 0, zero payload).
- R10: The invalid output is high when either operand is a signaling NaN or the core invalid flag is high, and low otherwise.
- R11: For every input pair and policy, swapping the two operands leaves the result and invalid output bit-identical.
- R12: With the output register enabled (default), result and invalid appear one clock after the inputs, and a synchronous active-high reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First source operand of the arithmetic core |
| op_b | input | 32 | Second source operand of the arithmetic core |
| core_res | input | 32 | Numeric result produced by the core |
| core_inv | input | 1 | Core signals a freshly generated invalid result |
| policy | input | 2 | Two-NaN policy: 00 larger, 01 OR, 10 smaller, 11 as 00 |
| res | output | 32 | Final result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The block holds no state beyond its output register, so any error in the classifier or the merge logic shows at the ports on the very next clock. A wrong payload comparison shows up as a result that changes when the operands are swapped. A missing quiet-bit force shows as bit 22 low on a NaN result. A faulty priority between NaN inputs and the core flag shows as a zero-payload NaN in place of a propagated one. Every directed vector is therefore applied in both operand orders, and both responses are compared with the expected pattern.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned FRAC_W = 23;
  localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W;
  localparam int unsigned PL_W  = FRAC_W - 1;

  typedef enum logic [1:0] {
    POL_MAX = 2'b00,
    POL_OR  = 2'b01,
    POL_MIN = 2'b10,
    POL_RSV = 2'b11
  } nan_policy_e;

  typedef struct packed {
    logic            sign;
    logic            is_nan;
    logic            is_snan;
    logic [PL_W-1:0] payload;
  } opnd_info_t;
endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
(
  input  logic [FP_W-1:0] val,
  output opnd_info_t      info
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = val[FP_W-2 -: EXP_W];
  assign frac_f = val[FRAC_W-1:0];

  always_comb begin
    info.sign    = val[FP_W-1];
    info.is_nan  = (&exp_f) && (|frac_f);
    info.is_snan = info.is_nan && !frac_f[FRAC_W-1];
    info.payload = frac_f[PL_W-1:0];
  end
endmodule

// File: rtl/nanprop_merge.sv
module nanprop_merge
  import nanprop_pkg::*;
(
  input  opnd_info_t      info_a,
  input  opnd_info_t      info_b,
  input  logic [1:0]      policy,
  input  logic [FP_W-1:0] core_res,
  input  logic            core_inv,
  output logic [FP_W-1:0] res,
  output logic            invalid
);
  nan_policy_e     pol;
  logic            sign_or;
  logic            pay_eq;
  logic            a_bigger;
  logic            both_sign;
  logic [PL_W-1:0] both_pay;

  function automatic logic [FP_W-1:0] make_qnan(input logic s, input logic [PL_W-1:0] p);
    return {s, {EXP_W{1'b1}}, 1'b1, p};
  endfunction

  assign pol      = nan_policy_e'(policy);
  assign sign_or  = info_a.sign | info_b.sign;
  assign pay_eq   = (info_a.payload == info_b.payload);
  assign a_bigger = (info_a.payload > info_b.payload);

  // Two-NaN combination; every arm is symmetric in a and b.
  always_comb begin
    both_sign = sign_or;
    both_pay  = info_a.payload;
    unique case (pol)
      POL_OR: begin
        both_sign = sign_or;
        both_pay  = info_a.payload | info_b.payload;
      end
      POL_MIN: begin
        if (pay_eq) begin
          both_sign = sign_or;
          both_pay  = info_a.payload;
        end else if (a_bigger) begin
          both_sign = info_b.sign;
          both_pay  = info_b.payload;
        end else begin
          both_sign = info_a.sign;
          both_pay  = info_a.payload;
        end
      end
      default: begin
        if (pay_eq) begin
          both_sign = sign_or;
          both_pay  = info_a.payload;
        end else if (a_bigger) begin
          both_sign = info_a.sign;
          both_pay  = info_a.payload;
        end else begin
          both_sign = info_b.sign;
          both_pay  = info_b.payload;
        end
      end
    endcase
  end

  always_comb begin
    if (info_a.is_nan && info_b.is_nan) res = make_qnan(both_sign, both_pay);
    else if (info_a.is_nan)             res = make_qnan(info_a.sign, info_a.payload);
    else if (info_b.is_nan)             res = make_qnan(info_b.sign, info_b.payload);
    else if (core_inv)                  res = make_qnan(1'b0, '0);
    else                                res = core_res;
  end

  assign invalid = info_a.is_snan | info_b.is_snan | core_inv;
endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
  import nanprop_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  input  logic [FP_W-1:0] core_res,
  input  logic            core_inv,
  input  logic [1:0]      policy,
  output logic [FP_W-1:0] res,
  output logic            invalid
);
  localparam int unsigned N_OPS = 2;

  logic [FP_W-1:0] ops [N_OPS];
  opnd_info_t      info [N_OPS];
  logic [FP_W-1:0] res_c;
  logic            inv_c;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    nanprop_classify u_cls (.val(ops[gi]), .info(info[gi]));
  end

  nanprop_merge u_merge (
    .info_a  (info[0]),
    .info_b  (info[1]),
    .policy  (policy),
    .core_res(core_res),
    .core_inv(core_inv),
    .res     (res_c),
    .invalid (inv_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res     <= '0;
        invalid <= 1'b0;
      end else begin
        res     <= res_c;
        invalid <= inv_c;
      end
    end

    // R1
    core_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (!info[0].is_nan && !info[1].is_nan && !core_inv) |=> (res == $past(core_res)));
    // R2
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (info[0].is_nan || info[1].is_nan) |=> (&res[FP_W-2 -: EXP_W] && res[FRAC_W-1]));
    // R2
    single_nan_pay_chk: assert property (@(posedge clk) disable iff (rst)
      (info[0].is_nan && !info[1].is_nan) |=> (res[PL_W-1:0] == $past(op_a[PL_W-1:0])));
    // R9
    zero_pay_chk: assert property (@(posedge clk) disable iff (rst)
      (!info[0].is_nan && !info[1].is_nan && core_inv) |=> (res == {1'b0, {EXP_W{1'b1}}, 1'b1, {PL_W{1'b0}}}));
    // R10
    snan_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (info[0].is_snan || info[1].is_snan) |=> invalid);
  end else begin : g_comb
    assign res     = res_c;
    assign invalid = inv_c;
  end
endmodule

// File: tb/tb_nanprop_unit.sv
`timescale 1ns/1ps
module tb_nanprop_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b, core_res;
  logic        core_inv;
  logic [1:0]  policy;
  logic [31:0] res;
  logic        invalid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nanprop_unit dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .core_res(core_res),
    .core_inv(core_inv), .policy(policy), .res(res), .invalid(invalid)
  );

  task automatic check(input string req, input logic [31:0] er, input logic ei);
    n_chk++;
    if (res !== er || invalid !== ei) begin
      n_fail++;
      $display("FAIL %s: res=%08h inv=%0b expected res=%08h inv=%0b", req, res, invalid, er, ei);
    end
  endtask

  // Applies a vector in both operand orders (R11 on every call).
  task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] cr, input logic ci, input logic [1:0] pol,
                       input logic [31:0] er, input logic ei);
    @(negedge clk);
    op_a = a; op_b = b; core_res = cr; core_inv = ci; policy = pol;
    @(negedge clk);
    check({req, " a,b"}, er, ei);
    op_a = b; op_b = a;
    @(negedge clk);
    check({req, " b,a R11"}, er, ei);
  endtask

  task automatic t_reset;
    rst = 1'b1; op_a = 32'h7F800001; op_b = 0; core_res = 32'hDEADBEEF; core_inv = 1; policy = 0;
    repeat (3) @(negedge clk);
    check("R12 reset", 32'h0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_core_pass;
    apply("R1 normal", 32'h3F800000, 32'h40000000, 32'h40400000, 0, 2'b00, 32'h40400000, 0);
    apply("R1 inf",    32'h7F800000, 32'h3F800000, 32'h7F800000, 0, 2'b01, 32'h7F800000, 0);
  endtask

  task automatic t_single_nan;
    apply("R2 qnan", 32'h7FC00005, 32'h3F800000, 32'h12345678, 0, 2'b00, 32'h7FC00005, 0);
    apply("R2 qnan core_inv", 32'hFFC0ABCD, 32'h00000000, 32'h7FC00000, 1, 2'b10, 32'hFFC0ABCD, 1);
  endtask

  task automatic t_snan_quiet;
    apply("R3 snan", 32'hFF800123, 32'h3F800000, 32'h0, 0, 2'b00, 32'hFFC00123, 1);
  endtask

  task automatic t_larger;
    apply("R4 larger", 32'h7FC00010, 32'hFFC00200, 32'h0, 0, 2'b00, 32'hFFC00200, 0);
  endtask

  task automatic t_or;
    apply("R5 or", 32'h7FC00011, 32'hFFC00102, 32'h0, 0, 2'b01, 32'hFFC00113, 0);
  endtask

  task automatic t_smaller;
    apply("R6 smaller", 32'h7FC00010, 32'hFFC00200, 32'h0, 0, 2'b10, 32'h7FC00010, 0);
  endtask

  task automatic t_equal;
    apply("R7 equal max", 32'h7FC00042, 32'hFFC00042, 32'h0, 0, 2'b00, 32'hFFC00042, 0);
    apply("R7 equal min", 32'h7FC00042, 32'hFFC00042, 32'h0, 0, 2'b10, 32'hFFC00042, 0);
  endtask

  task automatic t_reserved;
    apply("R8 reserved", 32'hFFC00300, 32'h7FC00301, 32'h0, 0, 2'b11, 32'h7FC00301, 0);
  endtask

  task automatic t_core_inv;
    apply("R9 core invalid", 32'h00000000, 32'h00000000, 32'h12345678, 1, 2'b00, 32'h7FC00000, 1);
  endtask

  task automatic t_flag;
    apply("R10 snan b", 32'h7FC00001, 32'h7F800002, 32'h0, 0, 2'b00, 32'h7FC00002, 1);
    apply("R10 quiet only", 32'h7FC00001, 32'h7FC00002, 32'h0, 0, 2'b01, 32'h7FC00003, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_core_pass();
    t_single_nan();
    t_snan_quiet();
    t_larger();
    t_or();
    t_smaller();
    t_equal();
    t_reserved();
    t_core_inv();
    t_flag();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end
endmodule